// File: doc/BRIEF.md
# SMBus Byte-Register Target with Alert Reply

This block is the target side of a two-wire SMBus/I2C link. It runs entirely in the system clock domain. SCL and SDA are oversampled through a two-stage synchroniser, and bus events are recognised as edges of the synchronised levels. The only output onto the bus is a pull-down enable for SDA. The surrounding pad logic turns that enable into an open-drain driver.

The target's 7-bit address is binary `10` followed by five strap bits. Behind that address sits a four-entry byte register file, reached through two transactions:

- **Write Byte:** address with write, command byte, data byte.
- **Read Byte:** address with write, command byte, repeated START, address with read. The target then returns one byte.

The command byte only sets a two-bit pointer. Its upper six bits are discarded.

While an external alert request input is high, the target also answers the bus-wide alert reply address. In that reply it returns its own address as the data byte. Once that byte has been shifted out, it emits a one-cycle clear pulse so the requester can drop the request.

Control pins are plain levels and pulses. The block has no streaming interface, so it has no back-pressure rules. The bus master paces every bit, and clock stretching is not provided.

Top module: `smbus_regslave`

## Requirements
- R1: The target acknowledges, by pulling SDA low during the ninth SCL pulse, an address byte whose upper seven bits equal {2'b10, strap_addr_i} (address sent MSB first, bit 0 being R/W with 0 = write, 1 = read).
- R2: After an address byte that matches neither its own address nor an active alert reply, the target leaves SDA released for every following bit until the next START or STOP.
- R3: In Write Byte, the data byte is stored in the register selected by bits [1:0] of the command byte; bits [7:2] of the command byte have no effect on which register is written.
- R4: In Read Byte, after the repeated START and the read address, the target drives the register selected by the preceding command byte MSB first, one bit per SCL pulse, changing SDA only after SCL falls.
- R5: With alert_req_i high, an address byte of 8'b0001_1001 (reply address 7'b0001100, R/W = 1) is acknowledged, the following byte driven is {2'b10, strap_addr_i, 1'b0}, and alert_clr_o pulses high for exactly one clock after that byte's eighth bit completes.
- R6: With alert_req_i low, the alert reply address is not acknowledged and alert_clr_o stays low.
- R7: A START or STOP arriving in the middle of a byte abandons the transaction and releases SDA; a data byte cut short this way does not change any register.
- R8: sda_pd_o begins pulling low only while SCL is low; START and STOP are taken as SDA falling and rising edges while SCL is high.
- R9: After reset, every register reads 8'h00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad (wired-AND of all drivers) |
| strap_addr_i | input | 5 | Low five bits of the target address |
| alert_req_i | input | 1 | Request to answer the alert reply address |
| sda_pd_o | output | 1 | SDA pull-down enable (1 = drive low) |
| alert_clr_o | output | 1 | One-cycle pulse after the alert reply byte has been sent |

## Verification
The hardest state to reach from the pins is a data byte that has been partly shifted in and is then cut off. The register must keep its old value, and the pointer must still be usable.

The bench writes a known value, then opens a second Write Byte to the same register and stops after four data bits. From that mid-byte point it issues a repeated START and a read. The value that comes back proves three things:
- the abort took effect;
- the pointer survived the interruption;
- the stale data was never committed.

A second hard state is the alert reply immediately after the request has been cleared. The bench models the requester, dropping alert_req_i on the clear pulse, and then retries the same reply address.

// File: rtl/smbus_pkg.sv
package smbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } bus_st_t;
endpackage

// File: rtl/smbus_cond_det.sv
module smbus_cond_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_sync[SYNC_STAGES-1];
      sda_q    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_lvl_o  = scl_sync[SYNC_STAGES-1];
  assign sda_lvl_o  = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_lvl_o & ~scl_q;
  assign scl_fall_o = ~scl_lvl_o & scl_q;
  assign start_o    = scl_lvl_o & scl_q & sda_q & ~sda_lvl_o;
  assign stop_o     = scl_lvl_o & scl_q & ~sda_q & sda_lvl_o;
endmodule

// File: rtl/smbus_regfile.sv
module smbus_regfile #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [NREG-1:0][DW-1:0] mem;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))  mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mem)); // R7
endmodule

// File: rtl/smbus_regslave.sv
module smbus_regslave #(
  parameter int          NREG     = 4,
  parameter int          DW       = 8,
  parameter int          STRAP_W  = 5,
  parameter logic [1:0]  ADDR_HI  = 2'b10,
  parameter logic [6:0]  ALERT_AD = 7'b0001100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_addr_i,
  input  logic               alert_req_i,
  output logic               sda_pd_o,
  output logic               alert_clr_o
);
  import smbus_pkg::*;

  localparam int PW = $clog2(NREG);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  bus_st_t st, after_ack;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, tx;
  logic [PW-1:0] ptr;
  logic          alert_pend;
  logic          wr_en;
  logic [DW-1:0] rd_data;
  logic [6:0]    own_addr;
  logic          byte_done, own_hit, ara_hit;

  smbus_cond_det #(.SYNC_STAGES(2)) i_det (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  smbus_regfile #(.NREG(NREG), .DW(DW)) i_rf (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en), .waddr_i(ptr),
    .wdata_i(sh), .raddr_i(ptr), .rdata_o(rd_data)
  );

  assign own_addr  = {ADDR_HI, strap_addr_i};
  assign byte_done = scl_fall && (cnt == LAST) && !start_ev && !stop_ev;
  assign own_hit   = (sh[7:1] == own_addr);
  assign ara_hit   = (sh[7:1] == ALERT_AD) && sh[0] && alert_req_i;
  assign wr_en     = (st == ST_WDAT) && byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      after_ack  <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      tx         <= '0;
      ptr        <= '0;
      sda_pd_o   <= 1'b0;
      alert_pend <= 1'b0;
      alert_clr_o <= 1'b0;
    end else begin
      alert_clr_o <= 1'b0;
      if (start_ev) begin
        st         <= ST_ADDR;
        cnt        <= '0;
        sda_pd_o   <= 1'b0;
        alert_pend <= 1'b0;
      end else if (stop_ev) begin
        st         <= ST_IDLE;
        sda_pd_o   <= 1'b0;
        alert_pend <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_CMD, ST_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_lvl};
              cnt <= cnt + CW'(1);
            end else if (byte_done) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (own_hit) begin
                  sda_pd_o  <= 1'b1;
                  st        <= ST_ACK;
                  after_ack <= sh[0] ? ST_TX : ST_CMD;
                  tx        <= rd_data;
                end else if (ara_hit) begin
                  sda_pd_o   <= 1'b1;
                  st         <= ST_ACK;
                  after_ack  <= ST_TX;
                  tx         <= {own_addr, 1'b0};
                  alert_pend <= 1'b1;
                end else begin
                  st <= ST_SKIP;
                end
              end else if (st == ST_CMD) begin
                ptr       <= sh[PW-1:0];
                sda_pd_o  <= 1'b1;
                st        <= ST_ACK;
                after_ack <= ST_WDAT;
              end else begin
                sda_pd_o  <= 1'b1;
                st        <= ST_ACK;
                after_ack <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              st       <= after_ack;
              cnt      <= '0;
              sda_pd_o <= (after_ack == ST_TX) ? ~tx[DW-1] : 1'b0;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + CW'(1);
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_pd_o    <= 1'b0;
                st          <= ST_MACK;
                alert_clr_o <= alert_pend;
                alert_pend  <= 1'b0;
              end else begin
                tx       <= {tx[DW-2:0], 1'b0};
                sda_pd_o <= ~tx[DW-2];
              end
            end
          end
          ST_MACK: if (scl_rise) st <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  AST_PD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd_o) |-> !scl_lvl); // R8
  AST_EVENT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> !sda_pd_o); // R7
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clr_o |=> !alert_clr_o); // R5
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_pd_o); // R2
endmodule

// File: tb/test_smbus_regslave.sv
module test_smbus_regslave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [4:0] strap = 5'h00;
  logic alert_req = 1'b0;
  logic sda_pd, alert_clr;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  int clr_cnt = 0;
  int pd_hits = 0;
  int bad_pd = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_line = m_sda & ~sda_pd;

  smbus_regslave i_smbus_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_addr_i(strap), .alert_req_i(alert_req),
    .sda_pd_o(sda_pd), .alert_clr_o(alert_clr)
  );

  logic pd_q = 1'b0;
  always @(posedge clk) begin
    if (alert_clr) begin
      clr_cnt <= clr_cnt + 1;
      alert_req <= 1'b0;
    end
    if (sda_pd) pd_hits <= pd_hits + 1;
    if (sda_pd && !pd_q && m_scl) bad_pd <= bad_pd + 1;
    pd_q <= sda_pd;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    m_scl = 1'b0; hq;
    m_sda = 1'b1; hq;
    m_scl = 1'b1; hq;
    m_sda = 1'b0; hq;
  endtask

  task automatic bus_stop;
    m_scl = 1'b0; hq;
    m_sda = 1'b0; hq;
    m_scl = 1'b1; hq;
    m_sda = 1'b1; hq;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_scl = 1'b0; hq;
      m_sda = b[i]; hq;
      m_scl = 1'b1; hq; hq;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_scl = 1'b0; hq;
    m_sda = 1'b1; hq;
    m_scl = 1'b1; hq;
    ack = !sda_line;
    hq;
  endtask

  task automatic read_byte(input bit nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b0; hq; hq;
      m_scl = 1'b1; hq;
      b[i] = sda_line;
      hq;
    end
    m_scl = 1'b0; hq;
    m_sda = nack; hq;
    m_scl = 1'b1; hq; hq;
  endtask

  function automatic logic [7:0] pat(input int r, input int s);
    return 8'(((r * 61) ^ (s * 8 + 5)) + 17);
  endfunction

  task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] d);
    bit a;
    bus_start;
    send_byte({2'b10, strap, 1'b0}, a); chk("R1 addr ack", a, 1);
    send_byte(cmd, a);                  chk("R3 cmd ack", a, 1);
    send_byte(d, a);                    chk("R3 data ack", a, 1);
    bus_stop;
  endtask

  task automatic rd_reg(input logic [7:0] cmd, output logic [7:0] d);
    bit a;
    bus_start;
    send_byte({2'b10, strap, 1'b0}, a); chk("R1 addr ack", a, 1);
    send_byte(cmd, a);                  chk("R4 cmd ack", a, 1);
    bus_start;
    send_byte({2'b10, strap, 1'b1}, a); chk("R4 read addr ack", a, 1);
    read_byte(1'b1, d);
    bus_stop;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    bit a;
    int s;
    repeat (5) @(posedge clk);
    #1;
    chk("R9 reset sda released", sda_pd, 0);
    rst_n = 1'b1;
    hq;
    for (int r = 0; r < 4; r++) begin
      rd_reg(8'(r), d);
      chk("R9 reset value", d, 0);
    end

    // sweep straps and registers; upper command bits vary and must not matter
    for (int k = 0; k < 3; k++) begin
      s = (k == 0) ? 0 : (k == 1) ? 5'h15 : 5'h1F;
      strap = 5'(s);
      for (int r = 0; r < 4; r++)
        wr_reg({6'(s + r * 13 + 1), 2'(r)}, pat(r, s));
      for (int r = 0; r < 4; r++) begin
        rd_reg({6'(s * 3 + r + 7), 2'(r)}, d);
        chk("R3 R4 readback", d, pat(r, s));
      end
    end

    // R2: foreign address is not acked and SDA stays released
    strap = 5'h0B;
    bus_start;
    pd_hits = 0;
    send_byte({2'b10, 5'h0A, 1'b0}, a); chk("R2 foreign addr nack", a, 0);
    send_byte(8'h00, a);                chk("R2 next byte nack", a, 0);
    chk("R2 no pull-down", pd_hits, 0);
    bus_stop;
    bus_start;
    send_byte({2'b11, 5'h0B, 1'b0}, a); chk("R1 top bits must be 10", a, 0);
    bus_stop;

    // R7: cut a data byte short by STOP, then by repeated START
    wr_reg(8'h02, 8'h5A);
    bus_start;
    send_byte({2'b10, strap, 1'b0}, a);
    send_byte(8'h02, a);
    send_bits(8'hFF, 4);
    bus_stop;
    rd_reg(8'h02, d); chk("R7 stop mid-byte keeps reg", d, 8'h5A);
    bus_start;
    send_byte({2'b10, strap, 1'b0}, a);
    send_byte(8'hFE, a);
    send_bits(8'h00, 4);
    bus_start;
    send_byte({2'b10, strap, 1'b1}, a); chk("R7 read after abort ack", a, 1);
    read_byte(1'b1, d);
    bus_stop;
    chk("R7 start mid-byte keeps reg", d, 8'h5A);

    // R5 / R6: alert reply
    clr_cnt = 0;
    alert_req = 1'b1;
    bus_start;
    send_byte(8'b0001_1001, a); chk("R5 alert addr ack", a, 1);
    read_byte(1'b1, d);
    bus_stop;
    chk("R5 alert data", d, {2'b10, 5'h0B, 1'b0});
    chk("R5 clear pulse count", clr_cnt, 1);
    chk("R5 request dropped", alert_req, 0);
    bus_start;
    send_byte(8'b0001_1001, a); chk("R6 alert without request", a, 0);
    bus_stop;
    chk("R6 no clear pulse", clr_cnt, 1);

    chk("R8 pull-down start with SCL low", bad_pd, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule